// File: doc/BRIEF.md
# Add-Subtract Fermat Factoring Engine

This block searches for a factor of an odd composite N by Fermat's difference-of-squares method. Its search loop uses only wide additions, subtractions, a sign test and a zero test. It has no multiplier, no square-root unit and no perfect-square test. The operand width is a synthesis-time parameter, so every operand moves as one full-width word, even when it is hundreds of bits wide.

A host computes a = floor(sqrt(N)) outside the block. It presents two seeds: the odd step x0 = 2a+1 and the signed residual r0 = a*a - N. It then pulses start. The engine takes one step per clock until the residual reaches zero. At that point it reports the factor (x - y)/2 and raises done. A 32-bit step counter records progress. A slice of its upper bits drives a small LED bank. After a factor is found, the LED bank shows a walking-light pattern instead of the counter bits.

Top module: `fermat_engine`

## Requirements
- R1: While reset is held and until the first start, busy_o and done_o are 0, iter_count_o is 0 and led_o is 0.
- R2: A start_i pulse loads x = seed_x_i, y = 1, r = seed_r_i and clears iter_count_o. busy_o is 1 in the cycle that follows the load edge.
- R3: Each iteration takes exactly one clock cycle whatever N is. iter_count_o rises by exactly 1 per iteration. done_o rises on the edge that follows the last iteration, so the time from the load edge to done is (iterations + 1) cycles.
- R4: In each iteration a positive residual has y subtracted from it and then y grows by 2. A negative residual has x added to it and then x grows by 2. The iteration count and the factor that result equal those of this recurrence.
- R5: When the residual is zero, busy_o falls and done_o rises on the same edge. factor_o then equals (x - y)/2, which divides N exactly.
- R6: Once set, done_o, factor_o and iter_count_o hold their values until the next start_i pulse.
- R7: While done_o is 0, led_o equals iter_count_o[LED_LSB+6:LED_LSB]. By default this is bits 31 down to 25.
- R8: While done_o is 1, led_o holds a single lit bit. It starts at bit 0 and rotates one place toward the MSB every 2^ANIM_W cycles. It wraps from bit 6 to bit 0.
- R9: If N is a perfect square (r0 = 0), the engine finishes after zero iterations and reports floor(sqrt(N)).
- R10: A start_i pulse while a search is running abandons that search and begins the new one from its seeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that loads the seeds and begins a search |
| seed_x_i | input | W+1 | Initial odd step 2*floor(sqrt(N))+1 |
| seed_r_i | input | W+1 | Initial residual floor(sqrt(N))^2 - N, two's complement |
| busy_o | output | 1 | High while a search runs |
| done_o | output | 1 | High from the moment a factor is found until the next start |
| factor_o | output | W | Factor found, (x - y)/2 |
| iter_count_o | output | CNT_W | Iterations since the last start |
| led_o | output | LED_N | Counter slice while searching, walking light once done |

## Verification
A perfect-square N finishes before any step is taken. A design that tested zero only after stepping would skip past that exit and search on. The case N = 15 has a residual that swings from negative to positive to zero, which catches a swapped update branch or a factor taken before the last step. Factors far apart, such as 3 * 4999, run for thousands of steps. They expose counter-increment errors and a residual that is too narrow, which wraps and never reaches zero. A restart in mid-search, the hold of done after completion, and the animation step timing are checked to the exact cycle, since an off-by-one in the divider or the clear logic moves the first rotation.

// File: rtl/fermat_pkg.sv
package fermat_pkg;
    typedef enum logic [1:0] {
        FE_IDLE = 2'd0,
        FE_RUN  = 2'd1,
        FE_DONE = 2'd2
    } fe_state_e;
endpackage

// File: rtl/fermat_step.sv
// One add/subtract step of the Fermat recurrence, purely combinational.
module fermat_step #(
    parameter int IW = 66
) (
    input  logic [IW-1:0] x_i,
    input  logic [IW-1:0] y_i,
    input  logic [IW-1:0] r_i,
    output logic [IW-1:0] x_o,
    output logic [IW-1:0] y_o,
    output logic [IW-1:0] r_o,
    output logic          zero_o
);
    logic neg;

    always_comb begin
        neg    = r_i[IW-1];
        zero_o = (r_i == '0);
        x_o    = x_i;
        y_o    = y_i;
        r_o    = r_i;
        if (neg) begin
            r_o = r_i + x_i;
            x_o = x_i + IW'(2);
        end else if (!zero_o) begin
            r_o = r_i - y_i;
            y_o = y_i + IW'(2);
        end
    end
endmodule

// File: rtl/fermat_led.sv
// LED driver: counter slice while searching, walking light once done.
module fermat_led #(
    parameter int LED_N  = 7,
    parameter int ANIM_W = 22
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             done_i,
    input  logic [LED_N-1:0] slice_i,
    output logic [LED_N-1:0] led_o
);
    typedef struct packed {
        logic [LED_N-1:0]  pat;
        logic [ANIM_W-1:0] div;
    } led_regs_t;

    led_regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!done_i) begin
            s_d.pat = LED_N'(1);
            s_d.div = '0;
        end else begin
            s_d.div = s_q.div + ANIM_W'(1);
            if (&s_q.div) begin
                s_d.pat = {s_q.pat[LED_N-2:0], s_q.pat[LED_N-1]};
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.pat <= LED_N'(1);
            s_q.div <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign led_o = done_i ? s_q.pat : slice_i;

    // R8
    anim_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |-> ($countones(led_o) == 1));

    // R8
    anim_rotate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && (&s_q.div)) |=> (!done_i || (led_o != $past(led_o))));
endmodule

// File: rtl/fermat_engine.sv
// Fermat factoring engine: sequencing, iteration counter, factor register.
module fermat_engine
    import fermat_pkg::*;
#(
    parameter int W       = 64,
    parameter int CNT_W   = 32,
    parameter int LED_N   = 7,
    parameter int LED_LSB = 25,
    parameter int ANIM_W  = 22
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [W:0]       seed_x_i,
    input  logic [W:0]       seed_r_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [W-1:0]     factor_o,
    output logic [CNT_W-1:0] iter_count_o,
    output logic [LED_N-1:0] led_o
);
    localparam int IW = W + 2;

    typedef struct packed {
        fe_state_e        st;
        logic [IW-1:0]    x;
        logic [IW-1:0]    y;
        logic [IW-1:0]    r;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     fac;
    } regs_t;

    regs_t s_d, s_q;

    logic [IW-1:0] x_nx, y_nx, r_nx, diff;
    logic          hit;

    fermat_step #(.IW(IW)) u_step (
        .x_i    (s_q.x),
        .y_i    (s_q.y),
        .r_i    (s_q.r),
        .x_o    (x_nx),
        .y_o    (y_nx),
        .r_o    (r_nx),
        .zero_o (hit)
    );

    always_comb begin
        s_d  = s_q;
        diff = s_q.x - s_q.y;
        case (s_q.st)
            FE_RUN: begin
                if (hit) begin
                    s_d.st  = FE_DONE;
                    s_d.fac = W'(diff >> 1);
                end else begin
                    s_d.x   = x_nx;
                    s_d.y   = y_nx;
                    s_d.r   = r_nx;
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end
            default: ;
        endcase
        if (start_i) begin
            s_d.st  = FE_RUN;
            s_d.x   = {1'b0, seed_x_i};
            s_d.y   = IW'(1);
            s_d.r   = {seed_r_i[W], seed_r_i};
            s_d.cnt = '0;
            s_d.fac = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.st  <= FE_IDLE;
            s_q.x   <= '0;
            s_q.y   <= '0;
            s_q.r   <= '0;
            s_q.cnt <= '0;
            s_q.fac <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o       = (s_q.st == FE_RUN);
    assign done_o       = (s_q.st == FE_DONE);
    assign factor_o     = s_q.fac;
    assign iter_count_o = s_q.cnt;

    fermat_led #(.LED_N(LED_N), .ANIM_W(ANIM_W)) u_led (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .done_i  (done_o),
        .slice_i (s_q.cnt[LED_LSB+LED_N-1:LED_LSB]),
        .led_o   (led_o)
    );

    // R2
    start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (busy_o && iter_count_o == '0));

    // R3
    iter_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !hit && !start_i) |=> (busy_o && iter_count_o == $past(iter_count_o) + CNT_W'(1)));

    // R4
    neg_branch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && s_q.r[IW-1] && !start_i) |=> (s_q.x == $past(s_q.x) + IW'(2) && $stable(s_q.y)));

    // R5
    finish_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && hit && !start_i) |=> (done_o && !busy_o));

    // R6
    done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !start_i) |=> (done_o && $stable(factor_o) && $stable(iter_count_o)));
endmodule

// File: tb/fermat_engine_tb.sv
`timescale 1ns/1ps
module fermat_engine_tb;
    localparam int W = 32;
    localparam int CNT_W = 32;
    localparam int LED_N = 7;
    localparam int LED_LSB = 2;
    localparam int ANIM_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [W:0] seed_x = '0;
    logic [W:0] seed_r = '0;
    logic busy, done;
    logic [W-1:0] factor;
    logic [CNT_W-1:0] count;
    logic [LED_N-1:0] led;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fermat_engine #(.W(W), .CNT_W(CNT_W), .LED_N(LED_N), .LED_LSB(LED_LSB), .ANIM_W(ANIM_W)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .seed_x_i(seed_x), .seed_r_i(seed_r),
        .busy_o(busy), .done_o(done), .factor_o(factor), .iter_count_o(count), .led_o(led)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint isqrt(input longint n);
        longint a = 0;
        while ((a + 1) * (a + 1) <= n) a++;
        return a;
    endfunction

    // Recurrence model from R4: returns steps, sets factor.
    task automatic model(input longint n, output longint steps, output longint fac);
        longint a = isqrt(n);
        longint x = 2 * a + 1;
        longint y = 1;
        longint r = a * a - n;
        steps = 0;
        while (r != 0) begin
            if (r > 0) begin r = r - y; y = y + 2; end
            else begin r = r + x; x = x + 2; end
            steps++;
        end
        fac = (x - y) / 2;
    endtask

    task automatic kick(input longint n);
        longint a = isqrt(n);
        longint r0 = a * a - n;
        @(negedge clk);
        seed_x = (W+1)'(2 * a + 1);
        seed_r = (W+1)'(r0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_case(input longint n, input bit check_led);
        longint steps, fac;
        int c = 0;
        bit led_seen = 0;
        model(n, steps, fac);
        kick(n);
        chk(busy == 1'b1 && count == 0, "R2 busy after load", longint'(busy), 1);
        while (!done && c < 20000) begin
            if (check_led && !led_seen && busy && count > 40) begin
                chk(led == count[LED_LSB+LED_N-1:LED_LSB], "R7 led counter slice",
                    longint'(led), longint'(count[LED_LSB+LED_N-1:LED_LSB]));
                led_seen = 1;
            end
            @(negedge clk);
            c++;
        end
        chk(c == steps + 1, "R3 cycles to done", c, steps + 1);
        chk(count == steps, "R4 iteration count", longint'(count), steps);
        chk(factor == fac && (n % longint'(factor)) == 0, "R5 factor divides N", longint'(factor), fac);
        chk(busy == 1'b0, "R5 busy low at done", longint'(busy), 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(busy == 0 && done == 0, "R1 reset flags", longint'({busy, done}), 0);
        chk(count == 0 && led == 0, "R1 reset counter and led", longint'(count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && count == 0, "R1 idle after reset", longint'({busy, done}), 0);
    endtask

    task automatic t_hold_and_anim;
        logic [W-1:0] f0;
        logic [CNT_W-1:0] k0;
        run_case(7063, 1);
        f0 = factor;
        k0 = count;
        chk(led == 7'b0000001, "R8 pattern starts at bit 0", longint'(led), 1);
        repeat (3) @(negedge clk);
        chk(led == 7'b0000001, "R8 no rotate before period", longint'(led), 1);
        @(negedge clk);
        chk(led == 7'b0000010, "R8 first rotation", longint'(led), 2);
        repeat (4 * 5) @(negedge clk);
        chk(led == 7'b1000000, "R8 reaches top bit", longint'(led), 64);
        repeat (4) @(negedge clk);
        chk(led == 7'b0000001, "R8 wraps to bit 0", longint'(led), 1);
        chk(done && factor == f0 && count == k0, "R6 done holds", longint'(factor), longint'(f0));
    endtask

    task automatic t_square;
        run_case(49, 0);
        chk(count == 0 && factor == 7, "R9 perfect square", longint'(factor), 7);
    endtask

    task automatic t_restart;
        kick(14997);
        repeat (50) @(negedge clk);
        chk(busy == 1'b1, "R10 first search running", longint'(busy), 1);
        run_case(15, 0);
        chk(factor == 3 && count == 2, "R10 restart result", longint'(factor), 3);
    endtask

    initial begin
        t_reset();
        run_case(15, 0);
        run_case(143, 0);
        run_case(10403, 0);
        run_case(21, 0);
        t_hold_and_anim();
        t_square();
        run_case(14997, 1);
        t_restart();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule